// File: doc/BRIEF.md
# Extended Capability Chain Walker

This engine traverses the singly linked list of extended capability headers kept in a 4 KB configuration space. It talks to that space through a synchronous single-port memory interface with one-cycle read latency and word addressing. Each 32-bit header holds a 16-bit capability ID in bits 15:0, a 4-bit version in bits 19:16, and a 12-bit byte offset of the following header in bits 31:20. The list always begins at byte offset 0x100. A next-offset of zero closes the list.

A find request takes a capability ID and returns two offsets: the offset of the matching header and the offset of the entry visited just before it. An ID too wide to fit in 16 bits can never match. Such a request therefore stops at the tail, and the predecessor result names the last entry. An append request writes a new header at a caller-chosen offset. When that offset is not the list head, the engine first walks to the tail and patches the tail's next field so that it points at the new entry.

One request is handled at a time. A single-cycle start pulse launches it, a single-cycle done pulse marks the results valid, and starts that arrive while the engine is busy are dropped.

Top module: `cap_chain_walker`

## Requirements
- R1: A find request (op=0) returns found_off equal to the byte offset of the first header, in chain order from 0x100, whose bits 15:0 equal req_id. prev_off is the offset visited before it, or 0 when the match is at 0x100. No error flag is set.
- R2: If the header at 0x100 reads as all zeros, the list is empty. A find returns found_off=0, prev_off=0 and no error.
- R3: A find with no match returns found_off=0 and prev_off set to the tail, which is the entry whose next field is 0. Any req_id with a nonzero bit above bit 15 never matches.
- R4: If a next field being followed is below 0x100, above 0xFF8, or not a multiple of 4, the walk ends with err_ptr=1, found_off=0 and prev_off set to the entry that held the bad pointer. No read is ever issued below word address 0x40.
- R5: A walk that would need more than MAX_STEPS header reads (default 1024) ends with err_loop=1 after exactly MAX_STEPS reads, with no memory write.
- R6: An append (op=1) at req_off=0x100 performs no read. It makes one write at word 0x40 of {12'h000, req_ver, req_id[15:0]} and returns found_off=0x100, prev_off=0.
- R7: An append at any other legal offset walks to the tail and makes exactly two writes. The first rewrites the tail header with bits 31:20 replaced by req_off and bits 19:0 kept. The second writes {12'h000, req_ver, req_id[15:0]} at req_off. It returns found_off=req_off and prev_off=tail.
- R8: An append whose req_off has bits 1:0 nonzero sets err_align. An append outside 0x100..0xFF8, or onto an empty list at an offset other than 0x100, sets err_ptr. In these cases no memory write occurs, at most one error flag is set, and found_off is 0.
- R9: done is high for exactly one cycle per accepted request, and busy is high from acceptance until done. A start while busy is ignored, causing no extra done and no extra memory access.
- R10: After reset, busy, done, mem_re, mem_we, found_off, prev_off and all error flags are 0.
- R11: Each header visited costs one read strobe. mem_re and mem_we are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when idle |
| op | input | 1 | 0 = find, 1 = append |
| req_id | input | 32 | Capability ID; bits above 15 make a find unmatchable |
| req_ver | input | 4 | Version for an appended header |
| req_off | input | 12 | Byte offset for an appended header |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| found_off | output | 12 | Matching or appended header offset, else 0 |
| prev_off | output | 12 | Predecessor or tail offset |
| err_ptr | output | 1 | Bad pointer or illegal append target |
| err_align | output | 1 | Append offset not 4-byte aligned |
| err_loop | output | 1 | Step limit reached |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |

## Verification
The step-limit abort is the hardest state to reach. No well-formed chain can hit it, so the stimulus plants a header at 0x100 whose next field points back to itself and searches for an ID that is absent. The bench then counts every read strobe until the abort. While that long walk is running, it fires a second start carrying an append to 0x100. This checks that the late request produces no write and no second done pulse.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_DATA,
    ST_LINK,
    ST_NEW
  } walk_state_e;

  localparam logic OP_FIND   = 1'b0;
  localparam logic OP_APPEND = 1'b1;

endpackage

// File: rtl/cap_ptr_check.sv
module cap_ptr_check #(
  parameter int OFF_W = 12,
  parameter int LO    = 'h100,
  parameter int HI    = 'hFF8
) (
  input  logic [OFF_W-1:0] off,
  output logic             ok
);
  localparam logic [OFF_W-1:0] LO_V = OFF_W'(LO);
  localparam logic [OFF_W-1:0] HI_V = OFF_W'(HI);

  always_comb begin
    ok = (off >= LO_V) && (off <= HI_V) && (off[1:0] == 2'b00);
  end
endmodule

// File: rtl/cap_hdr_eval.sv
module cap_hdr_eval #(
  parameter int ID_W     = 16,
  parameter int VER_W    = 4,
  parameter int OFF_W    = 12,
  parameter int REQ_ID_W = 32
) (
  input  logic [ID_W+VER_W+OFF_W-1:0] hdr,
  input  logic                        at_base,
  input  logic [REQ_ID_W-1:0]         req_id,
  output logic                        empty,
  output logic                        id_hit,
  output logic                        nxt_zero,
  output logic [OFF_W-1:0]            nxt
);
  localparam int DATA_W  = ID_W + VER_W + OFF_W;
  localparam int NXT_LSB = ID_W + VER_W;

  logic upper_clear;

  generate
    if (REQ_ID_W > ID_W) begin : g_wide
      assign upper_clear = (req_id[REQ_ID_W-1:ID_W] == '0);
    end else begin : g_narrow
      assign upper_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    nxt      = hdr[DATA_W-1:NXT_LSB];
    nxt_zero = (nxt == '0);
    empty    = at_base && (hdr == '0);
    id_hit   = upper_clear && (hdr[ID_W-1:0] == req_id[ID_W-1:0]);
  end
endmodule

// File: rtl/cap_step_guard.sv
module cap_step_guard #(
  parameter int MAX_STEPS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic limit_hit
);
  localparam int CNT_W = $clog2(MAX_STEPS) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_STEPS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    limit_hit = (cnt >= LAST);
  end
endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
  import cap_walk_pkg::*;
#(
  parameter int ID_W      = 16,
  parameter int VER_W     = 4,
  parameter int OFF_W     = 12,
  parameter int REQ_ID_W  = 32,
  parameter int BASE_OFF  = 'h100,
  parameter int LAST_OFF  = 'hFF8,
  parameter int MAX_STEPS = 1024,
  localparam int DATA_W   = ID_W + VER_W + OFF_W,
  localparam int ADDR_W   = OFF_W - 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                op,
  input  logic [REQ_ID_W-1:0] req_id,
  input  logic [VER_W-1:0]    req_ver,
  input  logic [OFF_W-1:0]    req_off,
  output logic                busy,
  output logic                done,
  output logic [OFF_W-1:0]    found_off,
  output logic [OFF_W-1:0]    prev_off,
  output logic                err_ptr,
  output logic                err_align,
  output logic                err_loop,
  output logic                mem_re,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int NXT_LSB = ID_W + VER_W;
  localparam logic [OFF_W-1:0] BASE_V = OFF_W'(BASE_OFF);

  function automatic logic [DATA_W-1:0] make_hdr(input logic [ID_W-1:0] id,
                                                 input logic [VER_W-1:0] ver);
    return {{OFF_W{1'b0}}, ver, id};
  endfunction

  walk_state_e state;

  logic                op_q;
  logic [REQ_ID_W-1:0] id_q;
  logic [VER_W-1:0]    ver_q;
  logic [OFF_W-1:0]    off_q;
  logic [OFF_W-1:0]    cur;
  logic [OFF_W-1:0]    prv;

  logic                empty, id_hit, nxt_zero, nxt_ok, req_ok, limit_hit;
  logic [OFF_W-1:0]    nxt;
  logic                accept;

  assign accept = (state == ST_IDLE) && start;
  assign busy   = (state != ST_IDLE);

  cap_hdr_eval #(
    .ID_W(ID_W), .VER_W(VER_W), .OFF_W(OFF_W), .REQ_ID_W(REQ_ID_W)
  ) hdr_eval_i (
    .hdr      (mem_rdata),
    .at_base  (cur == BASE_V),
    .req_id   (id_q),
    .empty    (empty),
    .id_hit   (id_hit),
    .nxt_zero (nxt_zero),
    .nxt      (nxt)
  );

  cap_ptr_check #(.OFF_W(OFF_W), .LO(BASE_OFF), .HI(LAST_OFF)) nxt_chk_i (
    .off (nxt),
    .ok  (nxt_ok)
  );

  cap_ptr_check #(.OFF_W(OFF_W), .LO(BASE_OFF), .HI(LAST_OFF)) req_chk_i (
    .off (req_off),
    .ok  (req_ok)
  );

  cap_step_guard #(.MAX_STEPS(MAX_STEPS)) guard_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (accept),
    .inc       (state == ST_DATA),
    .limit_hit (limit_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      op_q      <= OP_FIND;
      id_q      <= '0;
      ver_q     <= '0;
      off_q     <= '0;
      cur       <= '0;
      prv       <= '0;
      found_off <= '0;
      prev_off  <= '0;
      err_ptr   <= 1'b0;
      err_align <= 1'b0;
      err_loop  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q      <= op;
            id_q      <= req_id;
            ver_q     <= req_ver;
            off_q     <= req_off;
            found_off <= '0;
            prev_off  <= '0;
            err_ptr   <= 1'b0;
            err_align <= 1'b0;
            err_loop  <= 1'b0;
            if (op == OP_APPEND && req_off[1:0] != 2'b00) begin
              err_align <= 1'b1;
              done      <= 1'b1;
            end else if (op == OP_APPEND && !req_ok) begin
              err_ptr <= 1'b1;
              done    <= 1'b1;
            end else if (op == OP_APPEND && req_off == BASE_V) begin
              found_off <= BASE_V;
              mem_we    <= 1'b1;
              mem_addr  <= BASE_V[OFF_W-1:2];
              mem_wdata <= make_hdr(req_id[ID_W-1:0], req_ver);
              state     <= ST_NEW;
            end else begin
              cur      <= BASE_V;
              prv      <= '0;
              mem_re   <= 1'b1;
              mem_addr <= BASE_V[OFF_W-1:2];
              state    <= ST_READ;
            end
          end
        end

        ST_READ: begin
          mem_re <= 1'b0;
          state  <= ST_DATA;
        end

        ST_DATA: begin
          if (empty) begin
            err_ptr <= (op_q == OP_APPEND);
            done    <= 1'b1;
            state   <= ST_IDLE;
          end else if (op_q == OP_FIND && id_hit) begin
            found_off <= cur;
            prev_off  <= prv;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end else if (nxt_zero) begin
            prev_off <= cur;
            if (op_q == OP_APPEND) begin
              found_off <= off_q;
              mem_we    <= 1'b1;
              mem_addr  <= cur[OFF_W-1:2];
              mem_wdata <= {off_q, mem_rdata[NXT_LSB-1:0]};
              state     <= ST_LINK;
            end else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end else if (!nxt_ok) begin
            err_ptr  <= 1'b1;
            prev_off <= cur;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else if (limit_hit) begin
            err_loop <= 1'b1;
            prev_off <= cur;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            prv      <= cur;
            cur      <= nxt;
            mem_re   <= 1'b1;
            mem_addr <= nxt[OFF_W-1:2];
            state    <= ST_READ;
          end
        end

        ST_LINK: begin
          mem_we    <= 1'b1;
          mem_addr  <= off_q[OFF_W-1:2];
          mem_wdata <= make_hdr(id_q[ID_W-1:0], ver_q);
          state     <= ST_NEW;
        end

        ST_NEW: begin
          mem_we <= 1'b0;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end

        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cap_chain_walker_chk.sv
module cap_chain_walker_chk #(
  parameter int OFF_W    = 12,
  parameter int BASE_OFF = 'h100,
  localparam int ADDR_W  = OFF_W - 2
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [OFF_W-1:0]  found_off,
  input logic              err_ptr,
  input logic              err_align,
  input logic              err_loop,
  input logic              mem_re,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE_OFF >> 2);
  localparam logic [OFF_W-1:0]  BASE_V = OFF_W'(BASE_OFF);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_port_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  assert_read_window_R4: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_addr >= BASE_W));

  assert_single_err_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones({err_ptr, err_align, err_loop}) <= 1));

  assert_align_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    err_align |-> !mem_we);

  assert_found_legal_R1: assert property (@(posedge clk) disable iff (rst)
    (done && found_off != '0) |-> (found_off[1:0] == 2'b00 && found_off >= BASE_V));

  assert_loop_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
    (done && err_loop) |-> !mem_we);
endmodule

bind cap_chain_walker cap_chain_walker_chk #(
  .OFF_W    (OFF_W),
  .BASE_OFF (BASE_OFF)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .found_off (found_off),
  .err_ptr   (err_ptr),
  .err_align (err_align),
  .err_loop  (err_loop),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/cap_chain_walker_tb_top.sv
module cap_chain_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [31:0] req_id = '0;
  logic [3:0]  req_ver = '0;
  logic [11:0] req_off = '0;
  logic        busy, done, err_ptr, err_align, err_loop, mem_re, mem_we;
  logic [11:0] found_off, prev_off;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:1023];

  int checks = 0;
  int fails = 0;
  int reads = 0;
  int writes = 0;
  int dones = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cap_chain_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .req_id(req_id),
    .req_ver(req_ver), .req_off(req_off), .busy(busy), .done(done),
    .found_off(found_off), .prev_off(prev_off), .err_ptr(err_ptr),
    .err_align(err_align), .err_loop(err_loop), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_re) reads <= reads + 1;
    if (mem_we) writes <= writes + 1;
    if (done) dones <= dones + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog R9: act=%0d cycles exp=done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic poke(input logic [11:0] off, input logic [31:0] hdr);
    mem[off[11:2]] = hdr;
  endtask

  task automatic launch(input logic o, input logic [31:0] id, input logic [3:0] v,
                        input logic [11:0] off);
    @(negedge clk);
    reads = 0; writes = 0; dones = 0;
    start = 1'b1; op = o; req_id = id; req_ver = v; req_off = off;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 5000 && !done; n++) @(negedge clk);
    check("R9 done seen", 32'(done), 32'd1);
  endtask

  task automatic run(input logic o, input logic [31:0] id, input logic [3:0] v,
                     input logic [11:0] off);
    launch(o, id, v, off);
    wait_done();
  endtask

  // {op, id, ver, off, exp_found, exp_prev, exp_err{ptr,align,loop}}
  localparam int NV = 12;
  localparam logic [75:0] VECS [0:NV-1] = '{
    {1'b0, 32'h0000_0001, 4'h0, 12'h000, 12'h100, 12'h000, 3'b000}, // R1 head
    {1'b0, 32'h0000_000B, 4'h0, 12'h000, 12'h140, 12'h100, 3'b000}, // R1 middle
    {1'b0, 32'h0000_0010, 4'h0, 12'h000, 12'h200, 12'h140, 3'b000}, // R1 tail
    {1'b0, 32'h0000_0077, 4'h0, 12'h000, 12'h000, 12'h200, 3'b000}, // R3 absent
    {1'b0, 32'h0001_0001, 4'h0, 12'h000, 12'h000, 12'h200, 3'b000}, // R3 wide id
    {1'b1, 32'h0000_0022, 4'h3, 12'h300, 12'h300, 12'h200, 3'b000}, // R7 append
    {1'b0, 32'h0000_0022, 4'h0, 12'h000, 12'h300, 12'h200, 3'b000}, // R1 new entry
    {1'b1, 32'h0000_0044, 4'h1, 12'h302, 12'h000, 12'h000, 3'b010}, // R8 unaligned
    {1'b1, 32'h0000_0044, 4'h1, 12'hFFC, 12'h000, 12'h000, 3'b100}, // R8 window
    {1'b1, 32'h0000_0033, 4'h1, 12'hFF8, 12'hFF8, 12'h300, 3'b000}, // R7 top edge
    {1'b0, 32'h0002_0000, 4'h0, 12'h000, 12'h000, 12'hFF8, 3'b000}, // R3 new tail
    {1'b0, 32'h0000_0033, 4'h0, 12'h000, 12'hFF8, 12'h300, 3'b000}  // R1 last
  };

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", 32'(busy), 0);
    check("R10 done", 32'(done), 0);
    check("R10 mem strobes", 32'({mem_re, mem_we}), 0);
    check("R10 offsets", 32'({found_off, prev_off}), 0);
    check("R10 errors", 32'({err_ptr, err_align, err_loop}), 0);

    poke(12'h100, {12'h140, 4'h1, 16'h0001});
    poke(12'h140, {12'h200, 4'h2, 16'h000B});
    poke(12'h200, {12'h000, 4'h1, 16'h0010});

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      int exp_w;
      v = VECS[i];
      run(v[75], v[74:43], v[42:39], v[38:27]);
      check("R1 R3 R7 found_off", 32'(found_off), 32'(v[26:15]));
      check("R1 R3 R7 prev_off", 32'(prev_off), 32'(v[14:3]));
      check("R4 R8 error flags", 32'({err_ptr, err_align, err_loop}), 32'(v[2:0]));
      exp_w = (v[75] && v[2:0] == 3'b000) ? 2 : 0;
      check("R7 R8 write count", writes, exp_w);
      if (i == 2) check("R11 reads for third entry", reads, 3);
    end
    // R7 patched tails keep bits 19:0; new headers end the list
    check("R7 link 0x200", mem[12'h200 >> 2], {12'h300, 4'h1, 16'h0010});
    check("R7 link 0x300", mem[12'h300 >> 2], {12'hFF8, 4'h3, 16'h0022});
    check("R7 new 0xFF8", mem[12'hFF8 >> 2], {12'h000, 4'h1, 16'h0033});

    // R2 empty list
    clear_mem();
    run(1'b0, 32'h5, 4'h0, 12'h0);
    check("R2 found", 32'(found_off), 0);
    check("R2 prev", 32'(prev_off), 0);
    check("R2 errors", 32'({err_ptr, err_align, err_loop}), 0);
    // R8 append onto empty list at non-head offset
    run(1'b1, 32'h5, 4'h2, 12'h180);
    check("R8 empty append err_ptr", 32'(err_ptr), 1);
    check("R8 empty append writes", writes, 0);
    // R6 append at head
    run(1'b1, 32'h0000_00AB, 4'h7, 12'h100);
    check("R6 reads", reads, 0);
    check("R6 writes", writes, 1);
    check("R6 header", mem[12'h100 >> 2], {12'h000, 4'h7, 16'h00AB});
    check("R6 found", 32'(found_off), 32'h100);
    check("R6 prev", 32'(prev_off), 0);
    @(negedge clk);
    check("R9 done single cycle", 32'(done), 0);

    // R4 pointer below window
    clear_mem();
    poke(12'h100, {12'h080, 4'h1, 16'h0001});
    run(1'b0, 32'h9, 4'h0, 12'h0);
    check("R4 low err_ptr", 32'(err_ptr), 1);
    check("R4 low prev", 32'(prev_off), 32'h100);
    check("R4 low found", 32'(found_off), 0);
    // R4 misaligned pointer
    poke(12'h100, {12'h140, 4'h1, 16'h0001});
    poke(12'h140, {12'h162, 4'h1, 16'h0002});
    run(1'b0, 32'h9, 4'h0, 12'h0);
    check("R4 misaligned err_ptr", 32'(err_ptr), 1);
    check("R4 misaligned prev", 32'(prev_off), 32'h140);
    check("R4 misaligned reads", reads, 2);

    // R5 circular chain, plus R9 start while busy
    clear_mem();
    poke(12'h100, {12'h100, 4'h1, 16'h0005});
    launch(1'b0, 32'h9, 4'h0, 12'h0);
    repeat (20) @(negedge clk);
    check("R9 busy mid walk", 32'(busy), 1);
    start = 1'b1; op = 1'b1; req_id = 32'h66; req_off = 12'h100;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R5 err_loop", 32'(err_loop), 1);
    check("R5 reads", reads, 1024);
    check("R9 ignored start writes", writes, 0);
    repeat (10) @(negedge clk);
    check("R9 single done", dones, 1);
    check("R9 head untouched", mem[12'h100 >> 2], {12'h100, 4'h1, 16'h0005});

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule